// File: doc/BRIEF.md
# Packing Transmit/Receive Queue Pair for a Serial Shift Engine

This block sits between a 32-bit register bus and a serial shift engine. It holds two queues, each 32 entries of 32 bits. The bus writes outbound entries into the transmit queue, and the engine takes serial words from it. The engine delivers inbound serial words, which collect in the receive queue until the bus reads them.

In packed mode one 32-bit entry carries several short serial words. With 8-bit words an entry holds four of them, and with 16-bit words it holds two. The transmit side hands these words out one at a time, lowest slice first. The receive side builds each entry from consecutive inbound words, starting at the lowest slice. In unpacked mode every entry carries one serial word in its low-order bits.

The block reports a free-slot count for transmit and a filled-entry count for receive, together with full and empty flags for each queue. Four error flags record overflow and underflow on both queues. They stay set until software writes ones to clear them. Each queue also has a one-cycle flush.

Top module: `spi_pack_fifo`

## Requirements
- R1: After synchronous reset the transmit free count is 32 and the receive fill count is 0. Both empty flags are 1, both full flags are 0, all error flags are 0, and `bus_rx_data` is 0.
- R2: `lvl_word` carries the transmit free-slot count in bits [5:0] and the receive filled-entry count in bits [21:16]. All its other bits are 0. Each full flag is 1 exactly when its queue holds 32 entries, and each empty flag is 1 exactly when its queue holds 0.
- R3: With `pack_en`=0, every bus write stores one entry. Each engine pop presents one whole entry on `eng_tx_word`, and each engine push stores `eng_rx_word` unchanged as one entry.
- R4: `pack_sz` selects the packed word width: 0 gives 4 bits, 1 gives 8, 2 gives 16 and 3 gives 32. An entry then holds 32 divided by that width packed words.
- R5: With `pack_en`=1, `eng_tx_word` is the current slice of the head entry, zero-extended, starting from bits [w-1:0]. Each pop advances to the next slice. The entry leaves the queue on the pop of its last slice.
- R6: With `pack_en`=1, each engine push places the low w bits of `eng_rx_word` into the next slice of an assembly word, lowest slice first. Bits above w are ignored. The assembled entry enters the receive queue on the push that fills its last slice.
- R7: A bus write while the transmit queue is full is dropped and sets `err_flags[0]` (transmit overflow).
- R8: A bus read while the receive queue is empty loads 0 into `bus_rx_data` and sets `err_flags[3]` (receive underflow). A read of a non-empty queue loads the head entry one cycle later and removes it.
- R9: An engine pop while the transmit queue is empty sets `err_flags[1]` (transmit underflow) and changes no queue state. `eng_tx_word` reads 0 whenever the transmit queue is empty.
- R10: A completed receive entry that arrives while the receive queue is full is dropped and sets `err_flags[2]` (receive overflow). Fullness is judged before any read in the same cycle.
- R11: Error flags are sticky. Writing 1 to bit k of `err_clr` clears flag k. A new error in the same cycle wins over the clear.
- R12: A flush of a queue empties it in one cycle and resets its slice position, and on the receive side its assembly word. Bus and engine operations on that queue in the flush cycle are ignored and raise no error. Flags and `bus_rx_data` are unchanged.
- R13: Each queue accepts exactly 32 entries. A push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pack_en | input | 1 | Packed mode enable |
| pack_sz | input | 2 | Packed word width code (0:4, 1:8, 2:16, 3:32 bits) |
| bus_tx_wr | input | 1 | Bus write strobe into the transmit queue |
| bus_tx_data | input | 32 | Bus write data |
| bus_rx_rd | input | 1 | Bus read strobe from the receive queue |
| bus_rx_data | output | 32 | Registered read data |
| eng_tx_pop | input | 1 | Engine takes one serial word |
| eng_tx_word | output | 32 | Serial word presented to the engine |
| eng_rx_push | input | 1 | Engine delivers one serial word |
| eng_rx_word | input | 32 | Serial word from the engine |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| err_clr | input | 4 | Write-one-to-clear mask for `err_flags` |
| lvl_word | output | 32 | Level word: tx free [5:0], rx fill [21:16] |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| err_flags | output | 4 | Sticky errors: [0] tx overflow, [1] tx underflow, [2] rx overflow, [3] rx underflow |

## Verification
The queues are driven through every packing setting and through unpacked mode. Each setting runs four traffic mixes: fill-heavy, drain-heavy, balanced and bursty. Fill-heavy traffic pins each queue at 32 entries, which exposes overflow drops and tests that fullness is judged before a same-cycle read. Drain-heavy traffic keeps the queues empty, which exposes the underflow paths and the zero read value.

Running every pack width separates correct slice placement and entry release from off-by-one slice counting. Random data in the bits above the slice width shows whether those bits are masked on the receive side. Random flushes land in the middle of partly assembled or partly consumed entries, which shows whether slice state is cleared. Random error clears that coincide with new errors decide the precedence between set and clear.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [1:0] {
        PK_W4  = 2'd0,
        PK_W8  = 2'd1,
        PK_W16 = 2'd2,
        PK_W32 = 2'd3
    } pack_sz_e;

    typedef struct packed {
        logic     en;
        pack_sz_e sz;
    } pack_cfg_t;

    // error flag bit positions
    localparam int unsigned ERR_TX_OVF = 0;
    localparam int unsigned ERR_TX_UNF = 1;
    localparam int unsigned ERR_RX_OVF = 2;
    localparam int unsigned ERR_RX_UNF = 3;
    localparam int unsigned ERR_N      = 4;

    // index of the last slice inside one entry
    function automatic logic [2:0] last_slice(pack_cfg_t c);
        if (!c.en) return 3'd0;
        case (c.sz)
            PK_W4:   return 3'd7;
            PK_W8:   return 3'd3;
            PK_W16:  return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] slice_mask(pack_cfg_t c);
        if (!c.en) return 32'hFFFF_FFFF;
        case (c.sz)
            PK_W4:   return 32'h0000_000F;
            PK_W8:   return 32'h0000_00FF;
            PK_W16:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [4:0] slice_shift(pack_cfg_t c, logic [2:0] idx);
        logic [4:0] v;
        v = {2'b00, idx};
        if (!c.en) return 5'd0;
        return v << ({1'b0, c.sz} + 3'd2);
    endfunction

endpackage

// File: rtl/spf_queue.sv
module spf_queue #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R13
    q_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R13
    q_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop && !flush |=> full);

    // R12
    q_flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/spf_tx_unpack.sv
module spf_tx_unpack
    import spf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pack_cfg_t   cfg,
    input  logic        flush,
    input  logic        pop_req,
    input  logic [31:0] q_head,
    input  logic        q_empty,
    output logic        q_pop,
    output logic [31:0] word,
    output logic        underflow
);
    logic [2:0] idx;
    logic       at_last;
    logic       take;

    assign at_last   = (idx >= last_slice(cfg));
    assign take      = pop_req && !q_empty && !flush;
    assign q_pop     = take && at_last;
    assign underflow = pop_req && q_empty && !flush;
    assign word      = q_empty ? 32'd0
                                : ((q_head >> slice_shift(cfg, idx)) & slice_mask(cfg));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            idx <= '0;
        end else if (take) begin
            idx <= at_last ? 3'd0 : idx + 3'd1;
        end
    end

    // R9
    tx_unf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pop_req && q_empty && !flush |=> $stable(idx));

endmodule

// File: rtl/spf_rx_pack.sv
module spf_rx_pack
    import spf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pack_cfg_t   cfg,
    input  logic        flush,
    input  logic        push_req,
    input  logic [31:0] word_in,
    input  logic        q_full,
    output logic        q_push,
    output logic [31:0] q_data,
    output logic        overflow
);
    logic [31:0] acc;
    logic [2:0]  idx;
    logic [31:0] merged;
    logic        at_last;
    logic        fire;

    assign merged   = acc | ((word_in & slice_mask(cfg)) << slice_shift(cfg, idx));
    assign at_last  = (idx >= last_slice(cfg));
    assign fire     = push_req && !flush && at_last;
    assign q_data   = cfg.en ? merged : word_in;
    assign q_push   = fire && !q_full;
    assign overflow = fire && q_full;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc <= '0;
            idx <= '0;
        end else if (push_req) begin
            if (at_last) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= merged;
                idx <= idx + 3'd1;
            end
        end
    end

    // R6
    rx_acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (acc == 32'd0) && (idx == 3'd0));

endmodule

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pack_en,
    input  logic [1:0]  pack_sz,
    input  logic        bus_tx_wr,
    input  logic [31:0] bus_tx_data,
    input  logic        bus_rx_rd,
    output logic [31:0] bus_rx_data,
    input  logic        eng_tx_pop,
    output logic [31:0] eng_tx_word,
    input  logic        eng_rx_push,
    input  logic [31:0] eng_rx_word,
    input  logic        tx_flush,
    input  logic        rx_flush,
    input  logic [3:0]  err_clr,
    output logic [31:0] lvl_word,
    output logic        tx_full,
    output logic        tx_empty,
    output logic        rx_full,
    output logic        rx_empty,
    output logic [3:0]  err_flags
);
    localparam int CW = $clog2(DEPTH) + 1;

    pack_cfg_t     cfg;
    logic [31:0]   tx_head;
    logic [31:0]   rx_head;
    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_free;
    logic          tx_q_pop;
    logic          rx_q_push;
    logic [31:0]   rx_q_data;
    logic          tx_unf_ev;
    logic          rx_ovf_ev;
    logic          tx_ovf_ev;
    logic          rx_unf_ev;
    logic          rx_rd_ok;
    logic [ERR_N-1:0] err_set;
    logic [ERR_N-1:0] err_q;

    assign cfg.en = pack_en;
    assign cfg.sz = pack_sz_e'(pack_sz);

    spf_queue #(.WIDTH(32), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(bus_tx_wr), .push_data(bus_tx_data), .pop(tx_q_pop),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spf_tx_unpack u_txu (
        .clk(clk), .rst(rst), .cfg(cfg), .flush(tx_flush),
        .pop_req(eng_tx_pop), .q_head(tx_head), .q_empty(tx_empty),
        .q_pop(tx_q_pop), .word(eng_tx_word), .underflow(tx_unf_ev)
    );

    assign rx_rd_ok = bus_rx_rd && !rx_empty && !rx_flush;

    spf_queue #(.WIDTH(32), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_q_push), .push_data(rx_q_data), .pop(rx_rd_ok),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spf_rx_pack u_rxp (
        .clk(clk), .rst(rst), .cfg(cfg), .flush(rx_flush),
        .push_req(eng_rx_push), .word_in(eng_rx_word), .q_full(rx_full),
        .q_push(rx_q_push), .q_data(rx_q_data), .overflow(rx_ovf_ev)
    );

    assign tx_ovf_ev = bus_tx_wr && tx_full && !tx_flush;
    assign rx_unf_ev = bus_rx_rd && rx_empty && !rx_flush;

    always_comb begin
        err_set             = '0;
        err_set[ERR_TX_OVF] = tx_ovf_ev;
        err_set[ERR_TX_UNF] = tx_unf_ev;
        err_set[ERR_RX_OVF] = rx_ovf_ev;
        err_set[ERR_RX_UNF] = rx_unf_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q       <= '0;
            bus_rx_data <= '0;
        end else begin
            err_q <= err_set | (err_q & ~err_clr);
            if (bus_rx_rd && !rx_flush) begin
                bus_rx_data <= rx_empty ? 32'd0 : rx_head;
            end
        end
    end

    assign err_flags = err_q;
    assign tx_free   = CW'(DEPTH) - tx_cnt;

    always_comb begin
        lvl_word        = '0;
        lvl_word[5:0]   = 6'(tx_free);
        lvl_word[21:16] = 6'(rx_cnt);
    end

    generate
        for (genvar g = 0; g < ERR_N; g++) begin : g_sticky
            // R11
            err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
                err_q[g] && !err_clr[g] |=> err_q[g]);
        end
    endgenerate

    // R7
    tx_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        bus_tx_wr && tx_full && !tx_flush |=> err_flags[ERR_TX_OVF]);

    // R8
    rx_unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rx_rd && rx_empty && !rx_flush |=> (bus_rx_data == 32'd0) && err_flags[ERR_RX_UNF]);

    // R12
    tx_flush_free_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (lvl_word[5:0] == 6'(DEPTH)));

    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

endmodule

// File: tb/spi_pack_fifo_tb.sv
module spi_pack_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pack_en = 1'b0;
    logic [1:0]  pack_sz = 2'd0;
    logic        bus_tx_wr = 1'b0;
    logic [31:0] bus_tx_data = '0;
    logic        bus_rx_rd = 1'b0;
    logic [31:0] bus_rx_data;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_word;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_word = '0;
    logic        tx_flush = 1'b0;
    logic        rx_flush = 1'b0;
    logic [3:0]  err_clr = '0;
    logic [31:0] lvl_word;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [3:0]  err_flags;

    always #10 clk = ~clk;

    spi_pack_fifo dut_i (
        .clk(clk), .rst(rst), .pack_en(pack_en), .pack_sz(pack_sz),
        .bus_tx_wr(bus_tx_wr), .bus_tx_data(bus_tx_data),
        .bus_rx_rd(bus_rx_rd), .bus_rx_data(bus_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_word(eng_tx_word),
        .eng_rx_push(eng_rx_push), .eng_rx_word(eng_rx_word),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .err_clr(err_clr),
        .lvl_word(lvl_word), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .err_flags(err_flags)
    );

    int vectors = 0;
    int miscompares = 0;

    // reference state
    logic [31:0] mq_tx[$];
    logic [31:0] mq_rx[$];
    int          m_tidx = 0;
    int          m_ridx = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_rdata = '0;
    logic [3:0]  m_err = '0;
    logic        m_en = 1'b0;
    int          m_sz = 0;
    logic        last_flush = 1'b0;

    function automatic int f_width(int sz);
        return 4 << sz;
    endfunction

    function automatic int f_last(logic en, int sz);
        return en ? (8 >> sz) - 1 : 0;
    endfunction

    function automatic logic [31:0] f_mask(logic en, int sz);
        logic [63:0] m;
        if (!en) return 32'hFFFF_FFFF;
        m = (64'd1 << f_width(sz)) - 64'd1;
        return m[31:0];
    endfunction

    function automatic logic [31:0] exp_tx_word();
        if (mq_tx.size() == 0) return 32'd0;
        if (!m_en) return mq_tx[0];
        return (mq_tx[0] >> (m_tidx * f_width(m_sz))) & f_mask(m_en, m_sz);
    endfunction

    function automatic logic [31:0] exp_lvl();
        logic [31:0] v;
        v = '0;
        v[5:0]   = 6'(32 - mq_tx.size());
        v[21:16] = 6'(mq_rx.size());
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(last_flush ? "R12 level after flush" : "R13 level word", lvl_word, exp_lvl());
        chk("R2 full/empty flags", {28'd0, tx_full, tx_empty, rx_full, rx_empty},
            {28'd0, mq_tx.size() == 32, mq_tx.size() == 0,
                    mq_rx.size() == 32, mq_rx.size() == 0});
        if (mq_tx.size() == 0)
            chk("R9 tx word when empty", eng_tx_word, 32'd0);
        else if (m_en)
            chk("R4/R5 packed tx slice", eng_tx_word, exp_tx_word());
        else
            chk("R3 unpacked tx word", eng_tx_word, exp_tx_word());
        chk(m_en ? "R6 rx read data" : "R3/R8 rx read data", bus_rx_data, m_rdata);
        chk("R7 tx overflow flag",  {31'd0, err_flags[0]}, {31'd0, m_err[0]});
        chk("R9 tx underflow flag", {31'd0, err_flags[1]}, {31'd0, m_err[1]});
        chk("R10 rx overflow flag", {31'd0, err_flags[2]}, {31'd0, m_err[2]});
        chk("R8 rx underflow flag", {31'd0, err_flags[3]}, {31'd0, m_err[3]});
    endtask

    // advance the reference by one clock with the inputs now driven
    task automatic model_step();
        logic [3:0]  set;
        logic [31:0] merged;
        logic [31:0] data;
        logic        fire;
        bit          full_pre;
        bit          empty_pre;
        int          lst;
        set = '0;
        lst = f_last(m_en, m_sz);
        // transmit side
        if (tx_flush) begin
            mq_tx.delete();
            m_tidx = 0;
        end else begin
            full_pre  = (mq_tx.size() == 32);
            empty_pre = (mq_tx.size() == 0);
            if (eng_tx_pop) begin
                if (empty_pre) set[1] = 1'b1;
                else if (m_tidx >= lst) begin
                    void'(mq_tx.pop_front());
                    m_tidx = 0;
                end else m_tidx++;
            end
            if (bus_tx_wr) begin
                if (full_pre) set[0] = 1'b1;
                else mq_tx.push_back(bus_tx_data);
            end
        end
        // receive side
        if (rx_flush) begin
            mq_rx.delete();
            m_ridx = 0;
            m_acc  = '0;
        end else begin
            full_pre  = (mq_rx.size() == 32);
            empty_pre = (mq_rx.size() == 0);
            if (bus_rx_rd) begin
                if (empty_pre) begin
                    m_rdata = 32'd0;
                    set[3]  = 1'b1;
                end else m_rdata = mq_rx.pop_front();
            end
            fire = 1'b0;
            data = '0;
            if (eng_rx_push) begin
                if (m_en) begin
                    merged = m_acc | ((eng_rx_word & f_mask(m_en, m_sz)) << (m_ridx * f_width(m_sz)));
                    if (m_ridx >= lst) begin
                        fire = 1'b1; data = merged; m_acc = '0; m_ridx = 0;
                    end else begin
                        m_acc = merged; m_ridx++;
                    end
                end else begin
                    fire = 1'b1; data = eng_rx_word;
                end
            end
            if (fire) begin
                if (full_pre) set[2] = 1'b1;
                else mq_rx.push_back(data);
            end
        end
        // R11: set wins over write-one-to-clear
        m_err = set | (m_err & ~err_clr);
        last_flush = tx_flush;
    endtask

    task automatic idle_inputs();
        bus_tx_wr = 0; bus_rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
        tx_flush = 0; rx_flush = 0; err_clr = '0;
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: state while and right after reset
        chk("R1 reset level", lvl_word, 32'h0000_0020);
        chk("R1 reset flags", {28'd0, tx_full, tx_empty, rx_full, rx_empty}, 32'h5);
        chk("R1 reset errors", {28'd0, err_flags}, 32'd0);
        chk("R1 reset read data", bus_rx_data, 32'd0);
        rst = 0;
        @(negedge clk);
        check_all();

        // directed: read empty, pop empty, then clear with simultaneous new error
        bus_rx_rd = 1; eng_tx_pop = 1;
        cycle();
        idle_inputs();
        bus_rx_rd = 1; err_clr = 4'b1010;
        cycle();
        idle_inputs();
        err_clr = 4'hF;
        cycle();
        idle_inputs();

        // directed: fill tx to 32 and overflow
        for (int i = 0; i < 33; i++) begin
            bus_tx_wr = 1; bus_tx_data = 32'hA500_0000 + 32'(i);
            cycle();
        end
        idle_inputs();
        tx_flush = 1; rx_flush = 1; bus_tx_wr = 1; eng_rx_push = 1;
        cycle();
        idle_inputs();

        // randomised phases over every packing setting
        for (int ph = 0; ph < 6; ph++) begin
            idle_inputs();
            m_en = (ph >= 1 && ph <= 4);
            m_sz = (ph >= 1 && ph <= 4) ? ph - 1 : ph % 4;
            pack_en = m_en;
            pack_sz = 2'(m_sz);
            tx_flush = 1; rx_flush = 1; err_clr = 4'hF;
            cycle();
            for (int sp = 0; sp < 4; sp++) begin
                int pw;
                int pr;
                case (sp)
                    0: begin pw = 85; pr = 15; end
                    1: begin pw = 15; pr = 85; end
                    2: begin pw = 50; pr = 50; end
                    default: begin pw = 95; pr = 95; end
                endcase
                for (int c = 0; c < 600; c++) begin
                    bus_tx_wr   = ($urandom % 100) < pw;
                    bus_tx_data = $urandom;
                    eng_tx_pop  = ($urandom % 100) < pr;
                    eng_rx_push = ($urandom % 100) < pw;
                    eng_rx_word = $urandom;
                    bus_rx_rd   = ($urandom % 100) < pr;
                    tx_flush    = ($urandom % 200) == 0;
                    rx_flush    = ($urandom % 200) == 0;
                    err_clr     = (($urandom % 20) == 0) ? 4'($urandom) : 4'd0;
                    cycle();
                end
            end
        end
        idle_inputs();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule